// File: doc/BRIEF.md
# Predicate Register File with Compare Unit

This block holds the one-bit condition flags that gate issued instructions in a statically scheduled wide-issue core, together with the compare unit that writes them. On each clock it accepts at most one compare. A compare carries two operands, each with a deferred-exception ("not-a-thing") flag, a two-bit relation code, a two-bit compare kind, a qualifying flag index and two destination flag indices. A single compare can update two flags on the same clock edge.

Several read ports give the qualifying flag for each issue slot in the same cycle. Downstream logic turns a slot into a no-op when its enable reads low. Flag 0 always reads as one, so an instruction qualified by flag 0 always executes. Three compare kinds are supported. The qualified kind writes a result and its complement. The unconditional kind clears both destinations when its qualifier is false. The OR kind can only set its destinations, so several OR compares in sequence merge conditions into one flag.

Top module: `pred_cmp_unit`

## Requirements
- R1: The file holds 64 one-bit flags addressed by a 6-bit index; reset (rst_n low) clears flags 1 to 63.
- R2: Flag 0 always reads as 1; any compare that names index 0 as a destination leaves it at 1.
- R3: A qualified compare (kind 2'b00) whose qualifying flag is 1 writes the relation result to dest1 and its inverse to dest2 at the next rising clock edge.
- R4: Relation codes: 2'b00 equal, 2'b01 not-equal, 2'b10 signed less-than (a < b), 2'b11 unsigned less-than (a < b).
- R5: A qualified compare whose qualifying flag reads 0 changes neither destination.
- R6: An unconditional compare (kind 2'b01) writes 0 to both destinations when its qualifying flag is 0, and otherwise behaves as a qualified compare.
- R7: An OR compare (kind 2'b10) writes 1 to both destinations when its qualifying flag is 1, the relation holds and neither operand flag is set; otherwise both destinations keep their values. It never clears a flag.
- R8: For kinds 2'b00 and 2'b01, when either operand's not-a-thing flag is set (and the compare writes at all), both destinations are written 0.
- R9: When dest1 and dest2 name the same flag, the dest1 value is written.
- R10: Each read slot's enable shows the flag value held before any write of the same cycle; a new value appears after the clock edge that writes it.
- R11: Kind 2'b11 is reserved and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_kind | input | 2 | Compare kind (00 qualified, 01 unconditional, 10 OR, 11 reserved) |
| cmp_rel | input | 2 | Relation code |
| cmp_qp | input | 6 | Qualifying flag index |
| cmp_a | input | 64 | First operand |
| cmp_a_nat | input | 1 | First operand deferred-exception flag |
| cmp_b | input | 64 | Second operand |
| cmp_b_nat | input | 1 | Second operand deferred-exception flag |
| cmp_d1 | input | 6 | First destination flag index |
| cmp_d2 | input | 6 | Second destination flag index |
| rd_idx | input | 18 | Three packed 6-bit read indices, slot 0 in bits 5:0 |
| rd_en | output | 3 | Per-slot flag value (issue enable) |

## Verification
Compare results are due one clock after the compare is presented, because the only register on the path is the flag storage itself; read enables are combinational from that storage and need no extra cycle. The bench drives a compare on a falling edge and drops it one nanosecond after the next rising edge. It then moves the read index and samples the enable a nanosecond later, well clear of any edge. For the same-cycle read rule, the bench samples once just before the writing edge and once just after it, expecting the old value and then the new one.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [1:0] {
    REL_EQ  = 2'b00,
    REL_NE  = 2'b01,
    REL_SLT = 2'b10,
    REL_ULT = 2'b11
  } rel_e;

  typedef enum logic [1:0] {
    CK_QUAL = 2'b00,
    CK_UNC  = 2'b01,
    CK_OR   = 2'b10,
    CK_RSVD = 2'b11
  } kind_e;

  typedef struct packed {
    logic we1;
    logic v1;
    logic we2;
    logic v2;
  } wr_req_t;

endpackage

// File: rtl/pred_rel_eval.sv
module pred_rel_eval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        rel,
  output logic              hit
);
  import pred_pkg::*;

  function automatic logic relate(input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] y,
                                  input logic [1:0] code);
    logic r;
    case (rel_e'(code))
      REL_EQ:  r = (x == y);
      REL_NE:  r = (x != y);
      REL_SLT: r = ($signed(x) < $signed(y));
      default: r = (x < y);
    endcase
    return r;
  endfunction

  assign hit = relate(a, b, rel);
endmodule

// File: rtl/pred_wr_ctrl.sv
module pred_wr_ctrl #(
  parameter int IDX_W = 6
) (
  input  logic                     valid,
  input  logic [1:0]               kind,
  input  logic                     qp_true,
  input  logic                     hit,
  input  logic                     nat_any,
  input  logic [IDX_W-1:0]         d1,
  input  logic [IDX_W-1:0]         d2,
  output pred_pkg::wr_req_t        req
);
  import pred_pkg::*;

  wr_req_t raw;
  logic    same_dest;

  assign same_dest = (d1 == d2);

  always_comb begin
    raw = '0;
    if (valid) begin
      case (kind_e'(kind))
        CK_QUAL: if (qp_true) begin
          raw.we1 = 1'b1;
          raw.we2 = 1'b1;
          raw.v1  = hit & ~nat_any;
          raw.v2  = ~hit & ~nat_any;
        end
        CK_UNC: begin
          raw.we1 = 1'b1;
          raw.we2 = 1'b1;
          raw.v1  = qp_true & hit & ~nat_any;
          raw.v2  = qp_true & ~hit & ~nat_any;
        end
        CK_OR: if (qp_true && hit && !nat_any) begin
          raw.we1 = 1'b1;
          raw.we2 = 1'b1;
          raw.v1  = 1'b1;
          raw.v2  = 1'b1;
        end
        default: raw = '0;
      endcase
    end
  end

  always_comb begin
    req     = raw;
    req.we2 = raw.we2 & ~same_dest;
  end
endmodule

// File: rtl/pred_store.sv
module pred_store #(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pred_pkg::wr_req_t       req,
  input  logic [IDX_W-1:0]        d1,
  input  logic [IDX_W-1:0]        d2,
  input  logic [NUM_RD*IDX_W-1:0] rd_idx,
  output logic [NUM_RD-1:0]       rd_en,
  output logic [NUM_PRED-1:0]     pred_q
);

  for (genvar i = 0; i < NUM_PRED; i++) begin : g_flag
    if (i == 0) begin : g_const
      assign pred_q[i] = 1'b1;
    end else begin : g_reg
      logic hit1, hit2;
      assign hit1 = req.we1 && (d1 == IDX_W'(i));
      assign hit2 = req.we2 && (d2 == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pred_q[i] <= 1'b0;
        else if (hit1) pred_q[i] <= req.v1;
        else if (hit2) pred_q[i] <= req.v2;
      end
    end
  end

  for (genvar s = 0; s < NUM_RD; s++) begin : g_rd
    assign rd_en[s] = pred_q[rd_idx[s*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmp_valid,
  input  logic [1:0]              cmp_kind,
  input  logic [1:0]              cmp_rel,
  input  logic [IDX_W-1:0]        cmp_qp,
  input  logic [DATA_W-1:0]       cmp_a,
  input  logic                    cmp_a_nat,
  input  logic [DATA_W-1:0]       cmp_b,
  input  logic                    cmp_b_nat,
  input  logic [IDX_W-1:0]        cmp_d1,
  input  logic [IDX_W-1:0]        cmp_d2,
  input  logic [NUM_RD*IDX_W-1:0] rd_idx,
  output logic [NUM_RD-1:0]       rd_en
);
  import pred_pkg::*;

  logic [NUM_PRED-1:0] pred_q;
  logic                rel_hit;
  logic                nat_any;
  logic                qp_true;
  wr_req_t             wreq;

  assign nat_any = cmp_a_nat | cmp_b_nat;
  assign qp_true = pred_q[cmp_qp];

  pred_rel_eval #(.DATA_W(DATA_W)) u_eval (
    .a   (cmp_a),
    .b   (cmp_b),
    .rel (cmp_rel),
    .hit (rel_hit)
  );

  pred_wr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .valid   (cmp_valid),
    .kind    (cmp_kind),
    .qp_true (qp_true),
    .hit     (rel_hit),
    .nat_any (nat_any),
    .d1      (cmp_d1),
    .d2      (cmp_d2),
    .req     (wreq)
  );

  pred_store #(.NUM_PRED(NUM_PRED), .NUM_RD(NUM_RD)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (wreq),
    .d1     (cmp_d1),
    .d2     (cmp_d2),
    .rd_idx (rd_idx),
    .rd_en  (rd_en),
    .pred_q (pred_q)
  );
endmodule

// File: rtl/pred_cmp_checker.sv
module pred_cmp_checker #(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmp_valid,
  input logic [1:0]              cmp_kind,
  input logic [IDX_W-1:0]        cmp_qp,
  input logic                    cmp_a_nat,
  input logic                    cmp_b_nat,
  input logic [IDX_W-1:0]        cmp_d1,
  input logic [IDX_W-1:0]        cmp_d2,
  input logic [NUM_RD*IDX_W-1:0] rd_idx,
  input logic [NUM_RD-1:0]       rd_en,
  input logic [NUM_PRED-1:0]     pred_q
);

  a_r2_flag0_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[IDX_W-1:0] == '0) |-> rd_en[0]);

  a_r2_flag0_held: assert property (@(posedge clk) disable iff (!rst_n)
    pred_q[0]);

  a_r3_complement_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b00 && pred_q[cmp_qp] && !cmp_a_nat && !cmp_b_nat
     && cmp_d1 != cmp_d2 && cmp_d1 != '0 && cmp_d2 != '0)
    |=> (pred_q[$past(cmp_d1)] != pred_q[$past(cmp_d2)]));

  a_r5_qual_false_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b00 && !pred_q[cmp_qp]) |=> $stable(pred_q));

  a_r7_or_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b10) |=> (($past(pred_q) & ~pred_q) == '0));

  a_r8_nat_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b00 && pred_q[cmp_qp] && (cmp_a_nat || cmp_b_nat)
     && cmp_d1 != '0) |=> !pred_q[$past(cmp_d1)]);

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_kind == 2'b11) |=> $stable(pred_q));

endmodule

bind pred_cmp_unit pred_cmp_checker #(.NUM_PRED(NUM_PRED), .NUM_RD(NUM_RD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_kind  (cmp_kind),
  .cmp_qp    (cmp_qp),
  .cmp_a_nat (cmp_a_nat),
  .cmp_b_nat (cmp_b_nat),
  .cmp_d1    (cmp_d1),
  .cmp_d2    (cmp_d2),
  .rd_idx    (rd_idx),
  .rd_en     (rd_en),
  .pred_q    (pred_q)
);

// File: tb/pred_cmp_unit_bench.sv
module pred_cmp_unit_bench;
  localparam int NP = 64;
  localparam int IW = 6;
  localparam int DW = 64;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [1:0]    cmp_kind = '0;
  logic [1:0]    cmp_rel = '0;
  logic [IW-1:0] cmp_qp = '0;
  logic [DW-1:0] cmp_a = '0;
  logic          cmp_a_nat = 1'b0;
  logic [DW-1:0] cmp_b = '0;
  logic          cmp_b_nat = 1'b0;
  logic [IW-1:0] cmp_d1 = '0;
  logic [IW-1:0] cmp_d2 = '0;
  logic [NR*IW-1:0] rd_idx = '0;
  logic [NR-1:0] rd_en;

  int checks = 0;
  int errors = 0;
  logic mdl [NP];

  always #10 clk = ~clk;

  pred_cmp_unit u_pred_cmp_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
    .cmp_rel(cmp_rel), .cmp_qp(cmp_qp), .cmp_a(cmp_a), .cmp_a_nat(cmp_a_nat),
    .cmp_b(cmp_b), .cmp_b_nat(cmp_b_nat), .cmp_d1(cmp_d1), .cmp_d2(cmp_d2),
    .rd_idx(rd_idx), .rd_en(rd_en)
  );

  function automatic logic ref_rel(input logic [1:0] r, input logic [DW-1:0] a,
                                   input logic [DW-1:0] b);
    logic signed [DW:0] sa, sb;
    sa = {a[DW-1], a};
    sb = {b[DW-1], b};
    if (r == 2'd0) return a == b;
    if (r == 2'd1) return !(a == b);
    if (r == 2'd2) return (sa - sb) < 0;
    return {1'b0, a} < {1'b0, b};
  endfunction

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic read_flag(input int idx, output logic v);
    rd_idx[IW-1:0] = IW'(idx);
    #1;
    v = rd_en[0];
  endtask

  task automatic check_flag(input string tag, input int idx);
    logic v;
    read_flag(idx, v);
    expect_bit($sformatf("%s flag%0d", tag, idx), v, mdl[idx]);
  endtask

  task automatic do_cmp(input logic [1:0] kind, input logic [1:0] rel, input int qp,
                        input logic [DW-1:0] a, input logic an,
                        input logic [DW-1:0] b, input logic bn,
                        input int d1, input int d2);
    logic q, r, bad;
    q = mdl[qp];
    r = ref_rel(rel, a, b);
    bad = an | bn;
    @(negedge clk);
    cmp_valid = 1'b1; cmp_kind = kind; cmp_rel = rel; cmp_qp = IW'(qp);
    cmp_a = a; cmp_a_nat = an; cmp_b = b; cmp_b_nat = bn;
    cmp_d1 = IW'(d1); cmp_d2 = IW'(d2);
    @(posedge clk);
    #1;
    cmp_valid = 1'b0;
    // model: dest2 first so dest1 overrides on a shared index
    if (kind == 2'b00 && q) begin
      mdl[d2] = bad ? 1'b0 : !r;
      mdl[d1] = bad ? 1'b0 : r;
    end else if (kind == 2'b01) begin
      mdl[d2] = (q && !bad) ? !r : 1'b0;
      mdl[d1] = (q && !bad) ? r : 1'b0;
    end else if (kind == 2'b10 && q && r && !bad) begin
      mdl[d1] = 1'b1;
      mdl[d2] = 1'b1;
    end
    mdl[0] = 1'b1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NP; i++) mdl[i] = (i == 0);
    check_flag("R1 reset", 1);
    check_flag("R1 reset", 63);
    check_flag("R2 reset", 0);
  endtask

  task automatic t_relations;
    do_cmp(2'b00, 2'b00, 0, 64'd7, 0, 64'd7, 0, 1, 2);
    check_flag("R3 eq", 1); check_flag("R3 eq", 2);
    expect_bit("R4 eq literal", mdl[1], 1'b1);
    do_cmp(2'b00, 2'b01, 0, 64'd7, 0, 64'd7, 0, 3, 4);
    check_flag("R4 ne", 3); check_flag("R4 ne", 4);
    do_cmp(2'b00, 2'b10, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 0, 5, 6);
    check_flag("R4 slt", 5); check_flag("R4 slt", 6);
    expect_bit("R4 slt literal", mdl[5], 1'b1);
    do_cmp(2'b00, 2'b11, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 0, 7, 8);
    check_flag("R4 ult", 7); check_flag("R4 ult", 8);
    expect_bit("R4 ult literal", mdl[7], 1'b0);
  endtask

  task automatic t_flag0;
    do_cmp(2'b00, 2'b01, 0, 64'd1, 0, 64'd1, 0, 0, 9);
    check_flag("R2 write ignored", 0);
    check_flag("R2 companion", 9);
  endtask

  task automatic t_qualified_false;
    do_cmp(2'b00, 2'b00, 10, 64'd3, 0, 64'd3, 0, 3, 11);
    check_flag("R5 hold", 3); check_flag("R5 hold", 11);
    expect_bit("R5 literal", mdl[3], 1'b0);
  endtask

  task automatic t_unconditional;
    do_cmp(2'b00, 2'b00, 0, 64'd1, 0, 64'd1, 0, 12, 13);
    do_cmp(2'b01, 2'b00, 10, 64'd1, 0, 64'd1, 0, 12, 14);
    check_flag("R6 qp false clears", 12); check_flag("R6 qp false clears", 14);
    do_cmp(2'b01, 2'b10, 0, 64'd2, 0, 64'd9, 0, 15, 16);
    check_flag("R6 qp true", 15); check_flag("R6 qp true", 16);
  endtask

  task automatic t_or;
    do_cmp(2'b10, 2'b00, 0, 64'd1, 0, 64'd2, 0, 20, 21);
    check_flag("R7 false keeps", 20);
    do_cmp(2'b10, 2'b00, 0, 64'd2, 0, 64'd2, 0, 20, 21);
    check_flag("R7 set", 20); check_flag("R7 set", 21);
    do_cmp(2'b10, 2'b01, 0, 64'd2, 0, 64'd2, 0, 20, 21);
    check_flag("R7 never clears", 20);
    do_cmp(2'b10, 2'b00, 0, 64'd4, 1, 64'd4, 0, 22, 22);
    check_flag("R7 nat keeps", 22);
    do_cmp(2'b10, 2'b00, 10, 64'd4, 0, 64'd4, 0, 23, 23);
    check_flag("R7 qp false keeps", 23);
  endtask

  task automatic t_nat;
    do_cmp(2'b00, 2'b00, 0, 64'd5, 0, 64'd5, 1, 24, 25);
    check_flag("R8 nat b", 24); check_flag("R8 nat b", 25);
    do_cmp(2'b01, 2'b01, 0, 64'd5, 1, 64'd6, 0, 26, 27);
    check_flag("R8 nat a unc", 26); check_flag("R8 nat a unc", 27);
  endtask

  task automatic t_same_dest;
    do_cmp(2'b00, 2'b00, 0, 64'd8, 0, 64'd8, 0, 30, 30);
    check_flag("R9 dest1 wins", 30);
    expect_bit("R9 literal", mdl[30], 1'b1);
  endtask

  task automatic t_prewrite;
    logic v;
    rd_idx[2*IW +: IW] = IW'(40);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_kind = 2'b00; cmp_rel = 2'b00; cmp_qp = '0;
    cmp_a = 64'd1; cmp_a_nat = 1'b0; cmp_b = 64'd1; cmp_b_nat = 1'b0;
    cmp_d1 = IW'(40); cmp_d2 = IW'(41);
    #8;
    expect_bit("R10 old value before edge", rd_en[2], 1'b0);
    @(posedge clk);
    #1;
    cmp_valid = 1'b0;
    mdl[40] = 1'b1; mdl[41] = 1'b0;
    expect_bit("R10 new value after edge", rd_en[2], 1'b1);
    check_flag("R10", 41);
  endtask

  task automatic t_reserved;
    do_cmp(2'b11, 2'b00, 0, 64'd1, 0, 64'd1, 0, 42, 43);
    check_flag("R11 no write", 42); check_flag("R11 no write", 43);
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #25;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_relations;
    t_flag0;
    t_qualified_false;
    t_unconditional;
    t_or;
    t_nat;
    t_same_dest;
    t_prewrite;
    t_reserved;
    #20;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule